// File: doc/BRIEF.md
# Serial Control Register Write Port

This block is a write-only serial slave that loads a small bank of 8-bit control registers. A host pulls the active-low select line low and clocks out a 16-bit frame on the data line, one bit per rising edge of the serial clock. The frame carries an operation code, a register address and a data byte. The block keeps every register bit on a flat parallel bus, so the logic it configures can read the settings without any extra decoding.

The three serial pins are brought into the system clock through two-flop synchronisers and are then edge-detected. No flop is clocked by the serial clock. A frame takes effect only when the select line returns high. It is accepted only if exactly sixteen clock rises were counted, the third op-code bit is set and the address names one of the five registers. The power-down input and the calibration-busy input are synchronous to `clk`. Power-down returns every register to its reset value and blocks writes. Calibration-busy protects only register 1.

Top module: `ctl_wr_port`

## Requirements
- R1: After `rst_n` is released, register k sits on `cfg_bits[8k+7:8k]` and holds its reset value: reg0=05h, reg1=0Fh, reg2=34h, reg3=00h, reg4=00h.
- R2: Bits are sampled on rising edges of `sck` while `cs_n` is low. The frame order is op-code bits c0,c1,c2, then address bits a0..a4 (least significant first), then data bits d0..d7 (least significant first). A valid frame loads the data into the addressed register.
- R3: A frame is committed only when `cs_n` rises. While `cs_n` stays low after sixteen bits, the registers keep their old values.
- R4: A frame writes only if the third op-code bit c2 is 1. Bits c0 and c1 have no effect.
- R5: A frame with fewer or more than sixteen `sck` rises while `cs_n` is low is discarded.
- R6: A frame whose address is 5 to 31 changes no register.
- R7: While `pd_n` is low, all registers return to their reset values in the next cycle and frames are ignored.
- R8: While `cal_busy` is high, writes to register 1 are dropped and the other registers can still be written.
- R9: The upper four bits of reg0 and reg1 always read 0, whatever data is written.
- R10: A high level on `cs_n` clears the bit count and the shift register, so a frame abandoned part-way does not disturb the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; resets registers and blocks writes |
| cal_busy | input | 1 | Calibration in progress; protects register 1 |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cfg_bits | output | 40 | All register bits, register k at bits 8k+7..8k |

## Verification
The assertions check on every cycle that the upper nibbles of reg0 and reg1 stay at zero, and that a register changes only in the cycle after a select rise with a count of sixteen or after power-down. They also check that power-down restores the reset image and that register 1 does not move while calibration is busy. Bit order, the role of each op-code bit, out-of-range addresses, held-low select and recovery from an abandoned frame can only be shown by the bench's frame scenarios. The bench compares the full register image after each scenario.

// File: rtl/ctl_wr_pkg.sv
package ctl_wr_pkg;
  localparam int FRAME_BITS = 16;
  localparam int OP_BITS    = 3;
  localparam int ADDR_BITS  = 5;
  localparam int DATA_BITS  = 8;
  localparam int NUM_REGS   = 5;
  localparam int IMG_BITS   = NUM_REGS * DATA_BITS;

  // Power-on contents of each register.
  function automatic logic [DATA_BITS-1:0] reset_val(input int idx);
    case (idx)
      0:       reset_val = 8'h05;
      1:       reset_val = 8'h0F;
      2:       reset_val = 8'h34;
      default: reset_val = 8'h00;
    endcase
  endfunction

  // Bits that may hold a written 1 (the low two registers carry only a nibble).
  function automatic logic [DATA_BITS-1:0] keep_mask(input int idx);
    keep_mask = (idx < 2) ? 8'h0F : 8'hFF;
  endfunction

  function automatic logic [IMG_BITS-1:0] reset_image();
    logic [IMG_BITS-1:0] img;
    for (int k = 0; k < NUM_REGS; k++)
      img[k*DATA_BITS +: DATA_BITS] = reset_val(k);
    return img;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q,
  output logic rise
);
  logic [STAGES:0] pipe;
  logic [STAGES:0] pipe_nxt;

  always_comb pipe_nxt = {pipe[STAGES-1:0], d_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
    else        pipe <= pipe_nxt;
  end

  assign q    = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import ctl_wr_pkg::*;
#(
  parameter int NBITS = FRAME_BITS,
  parameter int OPW   = OP_BITS,
  parameter int AW    = ADDR_BITS,
  parameter int DW    = DATA_BITS,
  localparam int LIMIT = NBITS + 1,
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_q,
  input  logic          sel_rise,
  input  logic          bit_rise,
  input  logic          dat_q,
  output logic          frame_ok,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic [CW-1:0] bit_cnt
);
  logic [NBITS-1:0] sh, sh_nxt;
  logic [CW-1:0]    cnt_nxt;
  logic             unused_op;

  always_comb begin
    sh_nxt  = sh;
    cnt_nxt = bit_cnt;
    if (sel_q) begin
      sh_nxt  = '0;
      cnt_nxt = '0;
    end else if (bit_rise) begin
      sh_nxt = {dat_q, sh[NBITS-1:1]};
      if (bit_cnt != CW'(LIMIT)) cnt_nxt = bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else begin
      sh      <= sh_nxt;
      bit_cnt <= cnt_nxt;
    end
  end

  assign addr      = sh[OPW +: AW];
  assign data      = sh[OPW+AW +: DW];
  assign frame_ok  = sel_rise && (bit_cnt == CW'(NBITS)) && sh[OPW-1];
  assign unused_op = ^sh[OPW-2:0];
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import ctl_wr_pkg::*;
#(
  parameter int NREG        = NUM_REGS,
  parameter int AW          = ADDR_BITS,
  parameter int DW          = DATA_BITS,
  parameter int PROTECT_IDX = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             inhibit,
  input  logic             wr_ok,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  output logic [NREG*DW-1:0] cfg_bits
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DW-1:0] cur, nxt;
    logic          we;

    always_comb begin
      we  = wr_ok && pd_n && (addr == AW'(k)) && !(inhibit && (k == PROTECT_IDX));
      nxt = cur;
      if (!pd_n)   nxt = reset_val(k);
      else if (we) nxt = data & keep_mask(k);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= reset_val(k);
      else        cur <= nxt;
    end

    assign cfg_bits[k*DW +: DW] = cur;
  end
endmodule

// File: rtl/ctl_wr_port.sv
module ctl_wr_port
  import ctl_wr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pd_n,
  input  logic                cal_busy,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                sdi,
  output logic [IMG_BITS-1:0] cfg_bits
);
  localparam int CW = $clog2(FRAME_BITS + 2);

  logic cs_q, cs_rise, sck_q, sck_rise, sdi_q, sdi_rise;
  logic frame_ok;
  logic [ADDR_BITS-1:0] wr_addr;
  logic [DATA_BITS-1:0] wr_data;
  logic [CW-1:0]        bit_cnt;
  logic                 unused_edges;

  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d_in(cs_n), .q(cs_q), .rise(cs_rise));
  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d_in(sck), .q(sck_q), .rise(sck_rise));
  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync (
    .clk(clk), .rst_n(rst_n), .d_in(sdi), .q(sdi_q), .rise(sdi_rise));

  assign unused_edges = sck_q ^ sdi_rise;

  frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sel_q(cs_q), .sel_rise(cs_rise),
    .bit_rise(sck_rise), .dat_q(sdi_q), .frame_ok(frame_ok),
    .addr(wr_addr), .data(wr_data), .bit_cnt(bit_cnt));

  cfg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .inhibit(cal_busy),
    .wr_ok(frame_ok), .addr(wr_addr), .data(wr_data), .cfg_bits(cfg_bits));
endmodule

// File: rtl/ctl_wr_port_chk.sv
module ctl_wr_port_chk
  import ctl_wr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                pd_n,
  input logic                cal_busy,
  input logic [IMG_BITS-1:0] cfg_bits,
  input logic                cs_rise,
  input logic [4:0]          bit_cnt
);
  localparam logic [IMG_BITS-1:0] RST_IMG = reset_image();

  assert_pd_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (cfg_bits == RST_IMG));

  assert_nibble_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bits[7:4] == 4'h0) && (cfg_bits[15:12] == 4'h0));

  assert_commit_on_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_bits != $past(cfg_bits)) && $past(pd_n)) |-> $past(cs_rise));

  assert_exact_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_bits != $past(cfg_bits)) && $past(pd_n)) |-> ($past(bit_cnt) == 5'd16));

  assert_cal_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cal_busy) && $past(pd_n)) |-> (cfg_bits[15:8] == $past(cfg_bits[15:8])));
endmodule

bind ctl_wr_port ctl_wr_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cal_busy(cal_busy),
  .cfg_bits(cfg_bits), .cs_rise(cs_rise), .bit_cnt(bit_cnt));

// File: tb/test_ctl_wr_port.sv
module test_ctl_wr_port;
  logic clk = 1'b0;
  logic rst_n, pd_n, cal_busy, cs_n, sck, sdi;
  logic [39:0] cfg_bits;

  ctl_wr_port i_ctl_wr_port (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cal_busy(cal_busy),
    .cs_n(cs_n), .sck(sck), .sdi(sdi), .cfg_bits(cfg_bits));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [39:0] q_img[$];
  string       q_tag[$];
  logic [7:0]  m[5];
  bit          done = 0;

  function automatic logic [39:0] image();
    logic [39:0] r;
    for (int k = 0; k < 5; k++) r[k*8 +: 8] = m[k];
    return r;
  endfunction

  task automatic model_reset();
    m[0] = 8'h05; m[1] = 8'h0F; m[2] = 8'h34; m[3] = 8'h00; m[4] = 8'h00;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    q_img.push_back(image());
    q_tag.push_back(tag);
    tick(2);
  endtask

  // Shift nbits of {data,addr,op}; bit 0 of op goes first.
  task automatic shift_bits(input logic [2:0] op, input logic [4:0] a,
                            input logic [7:0] d, input int nbits);
    logic [15:0] f;
    f = {d, a, op};
    cs_n = 1'b0; tick(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? f[i] : 1'b0;
      sck = 1'b0; tick(4);
      sck = 1'b1; tick(4);
    end
    sck = 1'b0; tick(4);
  endtask

  task automatic close_frame(input logic [2:0] op, input logic [4:0] a,
                             input logic [7:0] d, input int nbits);
    cs_n = 1'b1; tick(8);
    if (nbits == 16 && op[2] && a < 5 && pd_n && !(cal_busy && a == 1))
      m[a] = (a < 2) ? (d & 8'h0F) : d;
  endtask

  task automatic send(input logic [2:0] op, input logic [4:0] a,
                      input logic [7:0] d, input int nbits, input string tag);
    shift_bits(op, a, d, nbits);
    close_frame(op, a, d, nbits);
    expect_now(tag);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: pops expected images and compares against the outputs.
  initial begin
    forever begin
      @(negedge clk);
      while (q_img.size() > 0) begin
        logic [39:0] e;
        string t;
        e = q_img.pop_front();
        t = q_tag.pop_front();
        n_cmp++;
        if (cfg_bits !== e) begin
          n_bad++;
          $display("FAIL %s: cfg_bits=%h expected=%h", t, cfg_bits, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; pd_n = 1'b1; cal_busy = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    model_reset();
    tick(4); rst_n = 1'b1; tick(2);
    expect_now("R1 reset image");

    send(3'b100, 5'd2, 8'hA5, 16, "R2 write reg2");
    send(3'b111, 5'd3, 8'h5A, 16, "R4 op c0c1 set, reg3");
    send(3'b100, 5'd4, 8'hC3, 16, "R2 write reg4");
    send(3'b011, 5'd3, 8'h11, 16, "R4 c2 clear ignored");
    send(3'b100, 5'd0, 8'hFF, 16, "R9 reg0 upper nibble");
    send(3'b100, 5'd1, 8'hA3, 16, "R9 reg1 upper nibble");
    send(3'b100, 5'd2, 8'h77, 15, "R5 15 bits discarded");
    send(3'b100, 5'd2, 8'h77, 17, "R5 17 bits discarded");
    send(3'b100, 5'd7, 8'h99, 16, "R6 address 7 ignored");
    send(3'b100, 5'd31, 8'h99, 16, "R6 address 31 ignored");

    shift_bits(3'b100, 5'd4, 8'h3C, 16);
    tick(12);
    expect_now("R3 held low, no commit");
    close_frame(3'b100, 5'd4, 8'h3C, 16);
    expect_now("R3 commit at cs rise");

    shift_bits(3'b111, 5'd0, 8'hFF, 5);
    close_frame(3'b111, 5'd0, 8'hFF, 5);
    send(3'b100, 5'd3, 8'hE1, 16, "R10 after aborted frame");

    cal_busy = 1'b1;
    send(3'b100, 5'd1, 8'h06, 16, "R8 reg1 blocked");
    send(3'b100, 5'd4, 8'h42, 16, "R8 reg4 writable");
    cal_busy = 1'b0;
    send(3'b100, 5'd1, 8'h06, 16, "R8 reg1 after calibration");

    pd_n = 1'b0; tick(2);
    model_reset();
    expect_now("R7 power-down reset");
    send(3'b100, 5'd2, 8'h12, 16, "R7 write blocked");
    pd_n = 1'b1; tick(2);
    send(3'b100, 5'd2, 8'h12, 16, "R7 write after release");

    tick(4);
    done = 1;
    report();
  end
endmodule